// File: doc/BRIEF.md
# Video Capture FIFO Status Tagger

This block sits in front of the write ports of a three-lane capture FIFO. Each cycle it may receive one 32-bit pixel or data word from the video timing front end. Along with the word come flags that mark the first and last word of a scan line, a valid-byte count for the last word, a flag for vertical-blanking data and a lane select. The block turns each word it accepts into a 36-bit FIFO entry: the word sits in bits 31:0 and a 4-bit status code sits in bits 35:32. That code tells the reading side where lines begin and end and how many bytes of the final word are valid.

The block also watches the field-parity signal, the capture enable and the packed/planar format select. When a captured field ends, it writes an entry that marks the end of the field and shows its parity. When a captured field begins, when capture is switched on partway through a field, or when the format changes while capture runs, it writes a format indicator. The indicator is spread across all three lanes, with lane 0 receiving a second copy in the next cycle. Marker entries carry zero data. A write that targets a full lane is dropped and sets a sticky overflow flag.

Top module: `vcap_status_tagger`

## Requirements
- R1: An accepted pixel word appears on its lane's write port after exactly one clock edge, with the word unchanged in entry bits 31:0 and the status code in bits 35:32.
- R2: Pixel status codes are 0010 for the first word of a line and 0000 for any other word. The last word of a line gets {pix_last_bytes, 01}, where pix_last_bytes 00 means four valid bytes, 11 means three, 10 means two and 01 means one. When a word is both first and last, the last-word code wins.
- R3: If a lane must be written while its fifo_full bit is high, that lane's write is suppressed and overflow goes high and stays high until reset. Other lanes are unaffected.
- R4: Pixel words are written only while cap_en is high. Words flagged as blanking data are written only if vbi_cap_en is also high.
- R5: In packed format (fmt_planar low) every pixel word goes to lane 0. In planar format it goes to the lane numbered by pix_lane, and the value 3 writes nothing.
- R6: When field changes level and capture was enabled in the previous cycle, an end-of-field entry with zero data is written to lane 0 one cycle after the change is sampled. The code is 0100 when field falls (end of an even field) and 1100 when field rises (end of an odd field). With capture off, a field change writes nothing.
- R7: A format indicator is produced when a field change is sampled with cap_en high, when cap_en rises, or when fmt_planar changes while capture stays on. Its code is 1110 for planar and 0110 for packed, and its data is zero.
- R8: A format indicator writes all three lanes in one cycle and lane 0 alone in the next cycle. If both markers are due, the end-of-field entry comes first, so the indicator starts two edges after the trigger, or one edge after it when there is no end-of-field entry.
- R9: Reset is synchronous and active high. It clears all write strobes and overflow. The field level present during reset is taken as the starting parity, so it does not count as a change.
- R10: While marker entries are being written, incoming pixel words are discarded. The front end must leave the three cycles after a trigger idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_en | input | 1 | Capture enable |
| vbi_cap_en | input | 1 | Enables capture of blanking-interval data words |
| field | input | 1 | Field parity level; high during the even field |
| fmt_planar | input | 1 | Current data format: 1 planar, 0 packed |
| pix_valid | input | 1 | Pixel/data word present this cycle |
| pix_data | input | 32 | Pixel/data word |
| pix_vbi | input | 1 | Word belongs to the blanking interval |
| pix_sol | input | 1 | First word of the scan line |
| pix_eol | input | 1 | Last word of the scan line |
| pix_last_bytes | input | 2 | Valid bytes in the last word (00 = four) |
| pix_lane | input | 2 | Target lane in planar format |
| fifo_full | input | 3 | Per-lane full indication |
| wr_en | output | 3 | Per-lane write strobe |
| wr_data | output | 108 | Per-lane 36-bit entry, lane i at bits 36*i+35:36*i |
| overflow | output | 1 | Sticky flag: a write was dropped on a full lane |

## Verification
The bench sweeps every combination of line-start and line-end flags, byte counts, blanking flag and blanking enable in packed format, and every lane select in planar format. A design that let start-of-line beat end-of-line, or that mapped byte counts wrongly, would show a wrong code on single-word lines or on partial last words. Field edges are driven in both directions with capture on and off. A design that swapped parity codes, marked the end of uncaptured fields, or put the indicator before the end-of-field entry would break the expected write sequence. The bench also sends pixel words into the marker window and writes into a full lane. This exposes a design that lets a pixel overwrite a marker slot, or one whose overflow flag clears or spills onto other lanes.

// File: rtl/vct_pkg.sv
package vct_pkg;
  localparam int DATA_W  = 32;
  localparam int CODE_W  = 4;
  localparam int ENTRY_W = DATA_W + CODE_W;

  localparam logic [CODE_W-1:0] C_PXV     = 4'b0000;
  localparam logic [CODE_W-1:0] C_SOL     = 4'b0010;
  localparam logic [CODE_W-1:0] C_PACKED  = 4'b0110;
  localparam logic [CODE_W-1:0] C_PLANAR  = 4'b1110;
  localparam logic [CODE_W-1:0] C_END_EVN = 4'b0100;
  localparam logic [CODE_W-1:0] C_END_ODD = 4'b1100;

  typedef enum logic [1:0] {
    SLOT_NONE,
    SLOT_END,
    SLOT_MODE_A,
    SLOT_MODE_B
  } slot_e;

  // Last-word code carries the byte count in its upper bits (00 = four).
  function automatic logic [CODE_W-1:0] pixel_code(input logic sol, input logic eol,
                                                    input logic [1:0] nbytes);
    if (eol)      return {nbytes, 2'b01};
    else if (sol) return C_SOL;
    else          return C_PXV;
  endfunction
endpackage

// File: rtl/vct_event_detect.sv
module vct_event_detect
  import vct_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              field,
  input  logic              cap_en,
  input  logic              fmt_planar,
  output logic              need_end,
  output logic [CODE_W-1:0] end_code,
  output logic              need_mode,
  output logic [CODE_W-1:0] mode_code
);
  logic field_q, cap_q, fmt_q;
  logic field_chg, fmt_chg;

  always_ff @(posedge clk) begin
    if (rst) begin
      field_q <= field;
      cap_q   <= 1'b0;
      fmt_q   <= fmt_planar;
    end else begin
      field_q <= field;
      cap_q   <= cap_en;
      fmt_q   <= fmt_planar;
    end
  end

  always_comb begin
    field_chg = field ^ field_q;
    fmt_chg   = fmt_planar ^ fmt_q;
    need_end  = field_chg & cap_q;
    end_code  = field_q ? C_END_EVN : C_END_ODD;
    need_mode = cap_en & (field_chg | ~cap_q | fmt_chg);
    mode_code = fmt_planar ? C_PLANAR : C_PACKED;
  end
endmodule

// File: rtl/vct_marker_seq.sv
module vct_marker_seq
  import vct_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              need_end,
  input  logic [CODE_W-1:0] end_code,
  input  logic              need_mode,
  input  logic [CODE_W-1:0] mode_code,
  output slot_e             slot,
  output logic [CODE_W-1:0] slot_code
);
  logic              end_pend, mode_pend, b_pend;
  logic [CODE_W-1:0] end_code_r, mode_code_r;

  always_comb begin
    if (end_pend) begin
      slot      = SLOT_END;
      slot_code = end_code_r;
    end else if (mode_pend) begin
      slot      = SLOT_MODE_A;
      slot_code = mode_code_r;
    end else if (b_pend) begin
      slot      = SLOT_MODE_B;
      slot_code = mode_code_r;
    end else begin
      slot      = SLOT_NONE;
      slot_code = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      end_pend    <= 1'b0;
      mode_pend   <= 1'b0;
      b_pend      <= 1'b0;
      end_code_r  <= '0;
      mode_code_r <= '0;
    end else begin
      end_pend  <= need_end;
      mode_pend <= need_mode | (mode_pend & end_pend);
      b_pend    <= (slot == SLOT_MODE_A);
      if (need_end)  end_code_r  <= end_code;
      if (need_mode) mode_code_r <= mode_code;
    end
  end
endmodule

// File: rtl/vct_lane_writer.sv
module vct_lane_writer
  import vct_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               req,
  input  logic [ENTRY_W-1:0] entry,
  input  logic               full,
  output logic               wr_en,
  output logic [ENTRY_W-1:0] wr_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en   <= 1'b0;
      wr_data <= '0;
    end else begin
      wr_en <= req & ~full;
      if (req & ~full) wr_data <= entry;
    end
  end
endmodule

// File: rtl/vcap_status_tagger.sv
module vcap_status_tagger
  import vct_pkg::*;
#(
  parameter int NUM_LANES  = 3,
  parameter int LANE_SEL_W = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cap_en,
  input  logic                         vbi_cap_en,
  input  logic                         field,
  input  logic                         fmt_planar,
  input  logic                         pix_valid,
  input  logic [DATA_W-1:0]            pix_data,
  input  logic                         pix_vbi,
  input  logic                         pix_sol,
  input  logic                         pix_eol,
  input  logic [1:0]                   pix_last_bytes,
  input  logic [LANE_SEL_W-1:0]        pix_lane,
  input  logic [NUM_LANES-1:0]         fifo_full,
  output logic [NUM_LANES-1:0]         wr_en,
  output logic [NUM_LANES*ENTRY_W-1:0] wr_data,
  output logic                         overflow
);
  logic              need_end, need_mode;
  logic [CODE_W-1:0] end_code, mode_code, slot_code, pix_code;
  slot_e             slot;
  logic              pix_ok;
  logic [LANE_SEL_W-1:0] tgt;
  logic [NUM_LANES-1:0]  lane_req;

  vct_event_detect u_evt (
    .clk       (clk),
    .rst       (rst),
    .field     (field),
    .cap_en    (cap_en),
    .fmt_planar(fmt_planar),
    .need_end  (need_end),
    .end_code  (end_code),
    .need_mode (need_mode),
    .mode_code (mode_code)
  );

  vct_marker_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .need_end (need_end),
    .end_code (end_code),
    .need_mode(need_mode),
    .mode_code(mode_code),
    .slot     (slot),
    .slot_code(slot_code)
  );

  always_comb begin
    pix_code = pixel_code(pix_sol, pix_eol, pix_last_bytes);
    tgt      = fmt_planar ? pix_lane : '0;
    pix_ok   = pix_valid & cap_en & (~pix_vbi | vbi_cap_en) & (slot == SLOT_NONE);
  end

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    logic               req;
    logic [ENTRY_W-1:0] ent;

    always_comb begin
      case (slot)
        SLOT_END, SLOT_MODE_B: req = (i == 0);
        SLOT_MODE_A:           req = 1'b1;
        default:               req = pix_ok && (tgt == LANE_SEL_W'(i));
      endcase
      ent = (slot == SLOT_NONE) ? {pix_code, pix_data} : {slot_code, {DATA_W{1'b0}}};
    end

    assign lane_req[i] = req;

    vct_lane_writer u_wr (
      .clk    (clk),
      .rst    (rst),
      .req    (req),
      .entry  (ent),
      .full   (fifo_full[i]),
      .wr_en  (wr_en[i]),
      .wr_data(wr_data[i*ENTRY_W +: ENTRY_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)                          overflow <= 1'b0;
    else if (|(lane_req & fifo_full)) overflow <= 1'b1;
  end
endmodule

// File: rtl/vct_checker.sv
module vct_checker
  import vct_pkg::*;
#(
  parameter int NUM_LANES = 3
) (
  input logic                         clk,
  input logic                         rst,
  input logic [NUM_LANES-1:0]         fifo_full,
  input logic [NUM_LANES-1:0]         wr_en,
  input logic [NUM_LANES*ENTRY_W-1:0] wr_data,
  input logic                         overflow
);
  logic [CODE_W-1:0] code0, code1;
  assign code0 = wr_data[DATA_W +: CODE_W];
  assign code1 = wr_data[ENTRY_W + DATA_W +: CODE_W];

  p_reset_quiet_r9: assert property (@(posedge clk)
    rst |=> (wr_en == '0) && !overflow);

  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  p_mode_pair_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en == '1 && (code1 == C_PACKED || code1 == C_PLANAR))
      |=> (wr_en == NUM_LANES'(1)) && (code0 == $past(code1)));

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_chk
    logic [CODE_W-1:0] c;
    logic [DATA_W-1:0] d;
    assign c = wr_data[i*ENTRY_W + DATA_W +: CODE_W];
    assign d = wr_data[i*ENTRY_W +: DATA_W];

    p_full_blocks_r3: assert property (@(posedge clk) disable iff (rst)
      wr_en[i] |-> !$past(fifo_full[i]));

    p_marker_zero_r6: assert property (@(posedge clk) disable iff (rst)
      (wr_en[i] && (c == C_END_EVN || c == C_END_ODD || c == C_PACKED || c == C_PLANAR))
        |-> (d == '0));
  end
endmodule

bind vcap_status_tagger vct_checker #(.NUM_LANES(NUM_LANES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .fifo_full(fifo_full),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .overflow (overflow)
);

// File: tb/tb_vcap_status_tagger.sv
module tb_vcap_status_tagger;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cap_en = 1'b0, vbi_cap_en = 1'b0, field = 1'b0, fmt_planar = 1'b0;
  logic         pix_valid = 1'b0, pix_vbi = 1'b0, pix_sol = 1'b0, pix_eol = 1'b0;
  logic [31:0]  pix_data = '0;
  logic [1:0]   pix_last_bytes = '0, pix_lane = '0;
  logic [2:0]   fifo_full = '0;
  logic [2:0]   wr_en;
  logic [107:0] wr_data;
  logic         overflow;
  int           n_tests = 0, n_fail = 0;
  bit           done = 1'b0;

  always #5 clk = ~clk;

  vcap_status_tagger dut (
    .clk(clk), .rst(rst), .cap_en(cap_en), .vbi_cap_en(vbi_cap_en), .field(field),
    .fmt_planar(fmt_planar), .pix_valid(pix_valid), .pix_data(pix_data),
    .pix_vbi(pix_vbi), .pix_sol(pix_sol), .pix_eol(pix_eol),
    .pix_last_bytes(pix_last_bytes), .pix_lane(pix_lane), .fifo_full(fifo_full),
    .wr_en(wr_en), .wr_data(wr_data), .overflow(overflow)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Compare strobes, and code/data on each strobed lane.
  task automatic expect_out(input logic [2:0] mask, input logic [3:0] code,
                            input logic [31:0] data, input string req);
    bit bad = 0;
    n_tests++;
    if (wr_en !== mask) bad = 1;
    for (int l = 0; l < 3; l++)
      if (mask[l] && wr_data[l*36 +: 36] !== {code, data}) bad = 1;
    if (bad) begin
      n_fail++;
      $display("FAIL %s: wr_en=%b data=%h expected wr_en=%b entry=%h", req, wr_en,
               wr_data, mask, {code, data});
    end
  endtask

  task automatic expect_ovf(input logic exp, input string req);
    n_tests++;
    if (overflow !== exp) begin
      n_fail++;
      $display("FAIL %s: overflow=%b expected=%b", req, overflow, exp);
    end
  endtask

  // Inputs that trigger the markers were set before this call.
  task automatic marker_seq(input bit has_end, input logic [3:0] ecode,
                            input logic [3:0] mcode, input string req);
    tick();
    expect_out(3'b000, 4'h0, 32'h0, req);
    if (has_end) begin
      tick();
      expect_out(3'b001, ecode, 32'h0, {req, " end marker R6"});
    end
    tick();
    expect_out(3'b111, mcode, 32'h0, {req, " mode all lanes R8"});
    tick();
    expect_out(3'b001, mcode, 32'h0, {req, " mode second copy R8"});
    tick();
    expect_out(3'b000, 4'h0, 32'h0, {req, " idle after markers"});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    expect_out(3'b000, 4'h0, 32'h0, "R9 reset strobes");
    expect_ovf(1'b0, "R9 reset overflow");

    // R6: field change with capture off writes nothing
    field = 1'b1;
    for (int k = 0; k < 4; k++) begin
      tick();
      expect_out(3'b000, 4'h0, 32'h0, "R6 uncaptured field change");
    end

    // R7: capture enabled mid-field -> packed indicator
    cap_en = 1'b1;
    marker_seq(0, 4'h0, 4'b0110, "R7 async enable packed");

    // R1 R2 R4 R5 sweep in packed format
    for (int v = 0; v < 64; v++) begin
      logic [3:0] ec;
      logic [2:0] em;
      pix_valid      = 1'b1;
      pix_sol        = v[0];
      pix_eol        = v[1];
      pix_last_bytes = v[3:2];
      pix_vbi        = v[4];
      vbi_cap_en     = v[5];
      pix_lane       = v[3:2];
      pix_data       = 32'h5A00_0000 ^ (32'(v) * 32'h0101_0103);
      ec = v[1] ? {v[3:2], 2'b01} : (v[0] ? 4'b0010 : 4'b0000);
      em = (!v[4] || v[5]) ? 3'b001 : 3'b000;
      tick();
      expect_out(em, ec, pix_data, "R1 R2 R4 R5 packed sweep");
    end
    pix_valid = 1'b0; pix_vbi = 1'b0; pix_sol = 1'b0; pix_eol = 1'b0;
    tick();

    // R4: capture off blocks pixels
    cap_en = 1'b0;
    tick();
    pix_valid = 1'b1; pix_data = 32'hDEAD_BEEF;
    tick();
    expect_out(3'b000, 4'h0, 32'h0, "R4 capture disabled");
    pix_valid = 1'b0;
    cap_en = 1'b1;
    marker_seq(0, 4'h0, 4'b0110, "R7 re-enable");

    // R7: format change to planar
    fmt_planar = 1'b1;
    marker_seq(0, 4'h0, 4'b1110, "R7 format change");

    // R5 planar lane routing
    for (int l = 0; l < 4; l++) begin
      pix_valid = 1'b1; pix_lane = 2'(l); pix_data = 32'h1000_0001 * 32'(l + 1);
      tick();
      expect_out(l < 3 ? 3'(1 << l) : 3'b000, 4'b0000, pix_data, "R5 planar lane");
    end
    pix_valid = 1'b0;

    // R6 R8: falling field (even end) then rising field (odd end)
    field = 1'b0;
    marker_seq(1, 4'b0100, 4'b1110, "R6 falling field");
    field = 1'b1;
    marker_seq(1, 4'b1100, 4'b1110, "R6 rising field");

    // R10: pixels during the marker window are discarded
    fmt_planar = 1'b0;
    tick();
    expect_out(3'b000, 4'h0, 32'h0, "R10 trigger cycle");
    pix_valid = 1'b1; pix_data = 32'hCAFE_F00D; pix_sol = 1'b1;
    tick();
    expect_out(3'b111, 4'b0110, 32'h0, "R10 marker wins slot A");
    tick();
    expect_out(3'b001, 4'b0110, 32'h0, "R10 marker wins slot B");
    pix_valid = 1'b0; pix_sol = 1'b0;
    tick();
    expect_out(3'b000, 4'h0, 32'h0, "R10 dropped pixel not written");

    // R3: overflow on a full lane
    fmt_planar = 1'b1;
    marker_seq(0, 4'h0, 4'b1110, "R7 back to planar");
    expect_ovf(1'b0, "R3 no overflow yet");
    fifo_full = 3'b010;
    pix_valid = 1'b1; pix_lane = 2'd1; pix_data = 32'h0BAD_0001;
    tick();
    expect_out(3'b000, 4'h0, 32'h0, "R3 full lane suppressed");
    expect_ovf(1'b1, "R3 overflow raised");
    pix_lane = 2'd0; pix_data = 32'h600D_0000; pix_eol = 1'b1; pix_last_bytes = 2'b10;
    tick();
    expect_out(3'b001, 4'b1001, 32'h600D_0000, "R3 other lane unaffected R2");
    pix_valid = 1'b0; pix_eol = 1'b0; fifo_full = 3'b000;
    repeat (3) tick();
    expect_ovf(1'b1, "R3 overflow sticky");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule